// File: doc/BRIEF.md
# Single-Slope Fast PWM Timer

This block is an 8-bit up-counting timer that produces a high-frequency pulse-width-modulated waveform on one output pin. A clock divider derived from the system clock advances the counter; the counter climbs from zero to its top value and then starts again from zero. Each period has one fixed edge, where the counter wraps, and one edge placed by a compare value. Software picks whether the waveform is normal or inverted.

The compare value is written into a holding register and copied into the live compare register only when the counter wraps. A new duty cycle therefore always starts on a clean period boundary. Two sticky flags report the wrap and the compare match. Each is cleared by a one-cycle strobe. A direction bit decides whether the pin is driven at all. A divider selection of zero stops the timer in place.

Top module: `fpwm_timer`

## Requirements
- R1: After synchronous reset, `cnt_o`, `pwm_o`, `pwm_oe`, `ovf_flag` and `cm_flag` are all 0. The held compare value, live compare value, mode and divider selection are also 0.
- R2: `ctl_csel` codes 1, 2, 3, 4 and 5 advance the counter once every 1, 8, 64, 256 and 1024 system clock cycles. The tick comes from a free-running divider counter that is cleared by reset. Codes 0, 6 and 7 give no ticks.
- R3: On each tick the counter increments by one from 0 up to 255. On the tick where it holds 255 it returns to 0.
- R4: `ovf_flag` is set on the same tick on which the counter goes from 255 to 0.
- R5: In mode 2 (`ctl_mode` = 2'b10, non-inverted), a wrap tick sets the pin register to 1. A tick taken while the counter equals the live compare value clears it to 0. When both happen on one tick, the wrap wins.
- R6: In mode 3 (`ctl_mode` = 2'b11, inverted), a wrap tick clears the pin register. A tick at compare match sets it. When both happen on one tick, the wrap wins.
- R7: In modes 0 and 1, `pwm_o` is 0 and the pin register holds its value.
- R8: `cmp_we` writes only the held compare value. The live compare value is loaded from the held value on the wrap tick, so a mid-period write changes only the following period.
- R9: `pwm_oe` equals the direction bit last written through `ctl_we`.
- R10: `cm_flag` is set on a tick taken while the counter equals the live compare value.
- R11: Each flag stays set until its clear strobe (`ovf_clr` or `cm_clr`) is high for a cycle. If a set and a clear fall in the same cycle, the flag ends up set.
- R12: While no ticks occur, the counter, the pin register and both flags hold their values. Clear strobes still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_we | input | 1 | Write strobe for the held compare value |
| cmp_wdata | input | 8 | Compare value to hold |
| ctl_we | input | 1 | Write strobe for mode, divider and direction |
| ctl_mode | input | 2 | Output mode: 0/1 off, 2 normal, 3 inverted |
| ctl_csel | input | 3 | Divider selection (0 stops) |
| ctl_dir | input | 1 | Direction bit; 1 drives the pin |
| ovf_clr | input | 1 | Clear strobe for the wrap flag |
| cm_clr | input | 1 | Clear strobe for the match flag |
| cnt_o | output | 8 | Current counter value |
| pwm_o | output | 1 | PWM pin value |
| pwm_oe | output | 1 | Pin output enable |
| ovf_flag | output | 1 | Sticky wrap flag |
| cm_flag | output | 1 | Sticky compare-match flag |

## Verification
Random traffic with held-value rewrites at random points in the period separates correct period-boundary loading from an immediate load. A rewrite landing before the old match point gives a different waveform under each scheme. Compare values of 0 and 255 are mixed in. They expose the wrap-versus-match priority, because only at 255 do the two edges share one tick. Directed duty measurements in both polarities separate a match edge taken on the tick leaving the compare value from one a tick earlier or later. Slower divider selections and a stopped interval separate a true per-tick advance from a per-cycle one.

// File: rtl/fpwm_pkg.sv
package fpwm_pkg;
  typedef enum logic [1:0] {
    OM_OFF_A  = 2'd0,
    OM_OFF_B  = 2'd1,
    OM_NORMAL = 2'd2,
    OM_INVERT = 2'd3
  } out_mode_e;

  localparam int DIV_SEL_W = 3;
endpackage

// File: rtl/fpwm_prescaler.sv
module fpwm_prescaler #(
  parameter int PRE_W = 10
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [fpwm_pkg::DIV_SEL_W-1:0] csel,
  output logic                          tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;
  logic             sel_ok;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else     pre_q <= pre_q + 1'b1;
  end

  always_comb begin
    sel_ok = 1'b1;
    unique case (csel)
      3'd1:    mask = '0;
      3'd2:    mask = PRE_W'(7);
      3'd3:    mask = PRE_W'(63);
      3'd4:    mask = PRE_W'(255);
      3'd5:    mask = PRE_W'(1023);
      default: begin mask = '0; sel_ok = 1'b0; end
    endcase
    tick = sel_ok && ((pre_q & mask) == mask);
  end
endmodule

// File: rtl/fpwm_core.sv
module fpwm_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             ovf_clr,
  input  logic             cm_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             at_top,
  output logic             at_match,
  output logic             ovf_flag,
  output logic             cm_flag
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] hold_q;
  logic [CNT_W-1:0] live_q;

  assign at_top   = (cnt == TOP);
  assign at_match = (cnt == live_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      hold_q   <= '0;
      live_q   <= '0;
      ovf_flag <= 1'b0;
      cm_flag  <= 1'b0;
    end else begin
      if (cmp_we) hold_q <= cmp_wdata;
      if (tick) begin
        if (at_top) begin
          cnt    <= '0;
          live_q <= hold_q;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (tick && at_top)  ovf_flag <= 1'b1;
      else if (ovf_clr)    ovf_flag <= 1'b0;
      if (tick && at_match) cm_flag <= 1'b1;
      else if (cm_clr)      cm_flag <= 1'b0;
    end
  end

  // R3: the tick at the top value returns the counter to zero
  a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick && at_top) |=> (cnt == '0));
  // R4: the wrap raises the overflow flag
  a_r4_ovf_on_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick && at_top) |=> ovf_flag);
  // R8: the live compare value changes only at the wrap
  a_r8_live_stable: assert property (@(posedge clk) disable iff (rst)
    !(tick && at_top) |=> $stable(live_q));
  // R11: a set beats a simultaneous clear
  a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
    (tick && at_match && cm_clr) |=> cm_flag);
  // R12: no tick, no counter motion
  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));
endmodule

// File: rtl/fpwm_wavegen.sv
module fpwm_wavegen (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                at_top,
  input  logic                at_match,
  input  fpwm_pkg::out_mode_e mode,
  output logic                pwm
);
  import fpwm_pkg::*;

  logic pin_q;
  logic active;
  logic invert;

  assign active = (mode == OM_NORMAL) || (mode == OM_INVERT);
  assign invert = (mode == OM_INVERT);

  always_ff @(posedge clk) begin
    if (rst) pin_q <= 1'b0;
    else if (tick && active) begin
      if (at_top)        pin_q <= ~invert;
      else if (at_match) pin_q <= invert;
    end
  end

  assign pwm = active ? pin_q : 1'b0;

  // R5: a wrap in normal mode leaves the pin high
  a_r5_wrap_sets: assert property (@(posedge clk) disable iff (rst)
    (tick && at_top && mode == OM_NORMAL) |=> pin_q);
  // R6: a wrap in inverted mode leaves the pin low
  a_r6_wrap_clears: assert property (@(posedge clk) disable iff (rst)
    (tick && at_top && mode == OM_INVERT) |=> !pin_q);
  // R7: disconnected modes keep the pin register still
  a_r7_off_holds: assert property (@(posedge clk) disable iff (rst)
    !active |=> $stable(pin_q));
endmodule

// File: rtl/fpwm_timer.sv
module fpwm_timer #(
  parameter int CNT_W = 8,
  parameter int PRE_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             ctl_we,
  input  logic [1:0]       ctl_mode,
  input  logic [2:0]       ctl_csel,
  input  logic             ctl_dir,
  input  logic             ovf_clr,
  input  logic             cm_clr,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pwm_o,
  output logic             pwm_oe,
  output logic             ovf_flag,
  output logic             cm_flag
);
  import fpwm_pkg::*;

  out_mode_e            mode_q;
  logic [DIV_SEL_W-1:0] csel_q;
  logic                 dir_q;
  logic                 tick;
  logic                 at_top;
  logic                 at_match;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= OM_OFF_A;
      csel_q <= '0;
      dir_q  <= 1'b0;
    end else if (ctl_we) begin
      mode_q <= out_mode_e'(ctl_mode);
      csel_q <= ctl_csel;
      dir_q  <= ctl_dir;
    end
  end

  assign pwm_oe = dir_q;

  fpwm_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .csel(csel_q), .tick(tick)
  );

  fpwm_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .tick(tick),
    .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .ovf_clr(ovf_clr), .cm_clr(cm_clr),
    .cnt(cnt_o), .at_top(at_top), .at_match(at_match),
    .ovf_flag(ovf_flag), .cm_flag(cm_flag)
  );

  fpwm_wavegen u_wave (
    .clk(clk), .rst(rst), .tick(tick),
    .at_top(at_top), .at_match(at_match),
    .mode(mode_q), .pwm(pwm_o)
  );

  // R9: the enable follows the direction bit written last
  a_r9_oe_follows: assert property (@(posedge clk) disable iff (rst)
    ctl_we |=> (pwm_oe == $past(ctl_dir)));
endmodule

// File: tb/sim_fpwm_timer.sv
`timescale 1ns/1ps
module sim_fpwm_timer;
  logic       clk = 1'b0;
  logic       rst;
  logic       cmp_we;
  logic [7:0] cmp_wdata;
  logic       ctl_we;
  logic [1:0] ctl_mode;
  logic [2:0] ctl_csel;
  logic       ctl_dir;
  logic       ovf_clr;
  logic       cm_clr;
  logic [7:0] cnt_o;
  logic       pwm_o, pwm_oe, ovf_flag, cm_flag;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // bench model state
  logic [9:0] m_pre;
  logic [7:0] m_cnt, m_hold, m_live;
  logic       m_pin, m_ovf, m_cm, m_dir;
  logic [1:0] m_mode;
  logic [2:0] m_csel;

  always #2 clk = ~clk;

  fpwm_timer u0 (
    .clk(clk), .rst(rst), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .ctl_we(ctl_we), .ctl_mode(ctl_mode), .ctl_csel(ctl_csel), .ctl_dir(ctl_dir),
    .ovf_clr(ovf_clr), .cm_clr(cm_clr), .cnt_o(cnt_o), .pwm_o(pwm_o),
    .pwm_oe(pwm_oe), .ovf_flag(ovf_flag), .cm_flag(cm_flag)
  );

  function automatic int div_of(input logic [2:0] s);
    case (s)
      3'd1: return 1;
      3'd2: return 8;
      3'd3: return 64;
      3'd4: return 256;
      3'd5: return 1024;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    int  d;
    bit  tk;
    if (rst) begin
      m_pre = '0; m_cnt = '0; m_hold = '0; m_live = '0;
      m_pin = 0; m_ovf = 0; m_cm = 0; m_dir = 0; m_mode = '0; m_csel = '0;
      return;
    end
    d  = div_of(m_csel);
    tk = (d != 0) && ((int'(m_pre) % d) == d - 1);
    // R4 / R10 / R11: flags, set winning over clear
    if (tk && m_cnt == 8'hFF) m_ovf = 1; else if (ovf_clr) m_ovf = 0;
    if (tk && m_cnt == m_live) m_cm = 1; else if (cm_clr) m_cm = 0;
    // R5 / R6: wrap edge first, match edge second
    if (tk && m_mode[1]) begin
      if (m_cnt == 8'hFF)       m_pin = (m_mode == 2'd2);
      else if (m_cnt == m_live) m_pin = (m_mode == 2'd3);
    end
    // R8: live value loads from the old held value at the wrap
    if (tk && m_cnt == 8'hFF) m_live = m_hold;
    if (cmp_we) m_hold = cmp_wdata;
    if (tk) m_cnt = m_cnt + 8'd1;
    if (ctl_we) begin m_mode = ctl_mode; m_csel = ctl_csel; m_dir = ctl_dir; end
    m_pre = m_pre + 10'd1;
  endtask

  task automatic compare_all();
    chk("R3 count", cnt_o, m_cnt);
    chk("R4 ovf_flag", ovf_flag, m_ovf);
    chk("R10 cm_flag", cm_flag, m_cm);
    chk("R9 pwm_oe", pwm_oe, m_dir);
    if (m_mode == 2'd2)      chk("R5 pwm normal", pwm_o, m_pin);
    else if (m_mode == 2'd3) chk("R6 pwm inverted", pwm_o, m_pin);
    else                     chk("R7 pwm off", pwm_o, 0);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
    cmp_we = 0; ctl_we = 0; ovf_clr = 0; cm_clr = 0; rst = 0;
  endtask

  task automatic set_ctl(input logic [1:0] md, input logic [2:0] cs, input logic dr);
    ctl_we = 1; ctl_mode = md; ctl_csel = cs; ctl_dir = dr;
    step();
  endtask

  task automatic write_cmp(input logic [7:0] v);
    cmp_we = 1; cmp_wdata = v;
    step();
  endtask

  task automatic run_to(input logic [7:0] v);
    for (int i = 0; i < 300000 && cnt_o != v; i++) step();
  endtask

  task automatic duty(input logic [1:0] md, input logic [7:0] v, input int exp_hi, input string tag);
    int hi;
    set_ctl(md, 3'd1, 1);
    write_cmp(v);
    run_to(8'hFF);
    step();              // wrap tick loads the live value
    hi = 0;
    for (int i = 0; i < 256; i++) begin
      if (pwm_o) hi++;
      step();
    end
    chk(tag, hi, exp_hi);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hang expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int gap;
    int t0;
    logic [7:0] c0;
    void'($urandom(32'd7321));
    rst = 1; cmp_we = 0; cmp_wdata = 0; ctl_we = 0; ctl_mode = 0; ctl_csel = 0;
    ctl_dir = 0; ovf_clr = 0; cm_clr = 0;
    @(negedge clk);
    step(); rst = 1; step();
    // R1: reset state
    chk("R1 cnt", cnt_o, 0); chk("R1 pwm", pwm_o, 0); chk("R1 oe", pwm_oe, 0);
    chk("R1 ovf", ovf_flag, 0); chk("R1 cm", cm_flag, 0);

    // R5 / R6: directed duty cycles
    duty(2'd2, 8'd100, 101, "R5 normal duty 100");
    duty(2'd3, 8'd100, 155, "R6 inverted duty 100");
    duty(2'd2, 8'd255, 256, "R5 normal duty top (wrap wins)");
    duty(2'd2, 8'd0, 1, "R5 normal duty zero");
    duty(2'd3, 8'd255, 0, "R6 inverted duty top (wrap wins)");

    // R8: mid-period write only affects the next period
    set_ctl(2'd2, 3'd1, 1);
    write_cmp(8'd50);
    run_to(8'hFF); step();
    run_to(8'd10);
    write_cmp(8'd200);
    run_to(8'd60);
    chk("R8 old value still live", pwm_o, 0);
    run_to(8'hFF); step();
    run_to(8'd150);
    chk("R8 new value live next period", pwm_o, 1);

    // R7: disconnected mode drives low
    set_ctl(2'd1, 3'd1, 1);
    run_to(8'd20);
    chk("R7 off mode pin", pwm_o, 0);

    // R2: divider 64 gap between advances
    set_ctl(2'd2, 3'd3, 1);
    c0 = cnt_o; step();
    for (int i = 0; i < 200 && cnt_o == c0; i++) step();
    c0 = cnt_o; gap = 0;
    for (int i = 0; i < 200 && cnt_o == c0; i++) begin step(); gap++; end
    chk("R2 divide-by-64 gap", gap, 64);

    // R12: stopped timer holds; clears still act
    set_ctl(2'd2, 3'd0, 1);
    c0 = cnt_o;
    for (int i = 0; i < 40; i++) step();
    chk("R12 count frozen", cnt_o, c0);
    ovf_clr = 1; cm_clr = 1; step();
    chk("R12 ovf cleared while stopped", ovf_flag, 0);
    chk("R12 cm cleared while stopped", cm_flag, 0);

    // R11: flag sticks until clear
    set_ctl(2'd2, 3'd1, 1);
    run_to(8'hFF); ovf_clr = 1; step();
    chk("R11 set wins over clear", ovf_flag, 1);
    for (int i = 0; i < 5; i++) step();
    chk("R11 flag sticky", ovf_flag, 1);
    ovf_clr = 1; step();
    chk("R11 clear strobe", ovf_flag, 0);

    // random phases across dividers 1, 8 and 1024 plus stop codes
    for (int ph = 0; ph < 12; ph++) begin
      t0 = $urandom_range(0, 9);
      set_ctl(2'($urandom_range(0, 3)),
              (t0 < 6) ? 3'd1 : (t0 < 8) ? 3'd2 : (t0 < 9) ? 3'd5 : 3'($urandom_range(6, 7)),
              1'($urandom_range(0, 1)));
      for (int i = 0; i < 3000; i++) begin
        if ($urandom_range(0, 15) == 0) begin
          cmp_we = 1;
          t0 = $urandom_range(0, 3);
          cmp_wdata = (t0 == 0) ? 8'd0 : (t0 == 1) ? 8'hFF : 8'($urandom_range(0, 255));
        end
        ovf_clr = ($urandom_range(0, 7) == 0);
        cm_clr  = ($urandom_range(0, 7) == 0);
        step();
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule